// File: doc/BRIEF.md
# Stretched-Cycle Processor Clock Generator

This block turns a fast master oscillator into the timing enables of a two-phase processor clock. Nearly every processor cycle has the same length, a fixed number of master ticks split evenly into a first phase and a second phase. During the first phase the processor leaves the memory bus alone, so other logic such as video fetch can use it. Once every 65 cycles the block adds a small number of extra ticks to one cycle. This keeps horizontal video timing in step with the colour subcarrier. Because of that stretch, the average processor rate is not a whole-number fraction of the master clock.

With a 14.31818 MHz master, the default build gives 14-tick cycles of about 978 ns. The long cycle has 16 ticks, about 1117 ns, and the average rate comes to about 1.0205 MHz. The block only produces enables. Subcarrier generation, pixel shifting and analog output are handled elsewhere. Downstream logic uses the enables in the master clock domain, together with a strobe that marks each cycle start, a flag that marks the long cycle, and the index of the current cycle.

Top module: `cpuclk_stretch`

## Requirements
- R1: While `rst_n` is low at a rising master edge, the block returns to tick 0 of cycle 0. Afterwards `phi1_en`=1, `phi2_en`=0, `cyc_start`=1, `long_cyc`=0 and `cyc_idx`=0.
- R2: A normal cycle lasts NORM_TICKS (14) master ticks. `phi1_en` is high for the first PH1_TICKS (7) of them and `phi2_en` is high for the rest.
- R3: On every master tick outside reset, exactly one of `phi1_en` and `phi2_en` is high.
- R4: `cyc_start` is high on tick 0 of every cycle and on no other tick, and it always coincides with `phi1_en`.
- R5: `cyc_idx` increases by one at each cycle start and wraps from CYCLES-1 (64) to 0. It holds its value within a cycle.
- R6: `long_cyc` is high on every tick of the cycle with index CYCLES-1 (64) and low during all other cycles.
- R7: The cycle with index 64 lasts NORM_TICKS+EXTRA_TICKS (16) ticks. The extra ticks extend the second phase, so `phi2_en` stays high for 9 ticks while `phi1_en` keeps its 7.
- R8: A full round of 65 cycles, from one start of cycle 0 to the next, takes exactly 64×14+16 = 912 master ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phi1_en | output | 1 | High during the first processor phase (bus idle) |
| phi2_en | output | 1 | High during the second processor phase |
| cyc_start | output | 1 | High on the first master tick of each processor cycle |
| long_cyc | output | 1 | High throughout the stretched cycle |
| cyc_idx | output | 7 | Index of the current processor cycle, 0 to 64 |

## Verification
The bench builds the block with its default parameters: 14-tick cycles, a 2-tick stretch, a 7-tick first phase and 65 cycles per round. A whole round is therefore 912 ticks, so several complete rounds fit easily in a short run. Every wrap from 64 back to 0 and every stretched cycle is compared tick by tick against the behavioural model. The measured cycle lengths, second-phase lengths and round length are also checked. A reset applied in the middle of a cycle shows that the block restarts cleanly from any point in its sequence.

// File: rtl/cpuclk_pkg.sv
// Package cpuclk_pkg
// Holds the default timing constants shared by the clock generator modules.
// Assumes a master clock of roughly 14.318 MHz for the quoted durations.
package cpuclk_pkg;
    localparam int unsigned DEF_NORM_TICKS  = 14; // master ticks in a normal cycle
    localparam int unsigned DEF_EXTRA_TICKS = 2;  // ticks added to the long cycle
    localparam int unsigned DEF_PH1_TICKS   = 7;  // ticks of the first phase
    localparam int unsigned DEF_CYCLES      = 65; // cycles per round; the last is long
endpackage

// File: rtl/cpuclk_phase_timer.sv
// Module cpuclk_phase_timer
// Counts master ticks within one processor cycle.
// It wraps after NORM ticks, or after NORM+EXTRA ticks when stretch is high.
// Assumes stretch is stable for the whole cycle, since it comes from the cycle index.
module cpuclk_phase_timer #(
    parameter int unsigned NORM  = 14,
    parameter int unsigned EXTRA = 2,
    localparam int unsigned TW   = $clog2(NORM + EXTRA)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stretch,
    output logic [TW-1:0] tick,
    output logic          last_tick
);
    localparam logic [TW-1:0] LAST_NORM = TW'(NORM - 1);
    localparam logic [TW-1:0] LAST_LONG = TW'(NORM + EXTRA - 1);

    // Flag the final tick of the current cycle, which depends on the cycle length.
    always_comb begin
        last_tick = (tick == (stretch ? LAST_LONG : LAST_NORM));
    end

    // Advance the tick counter and restart it after the final tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (last_tick) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        last_tick |=> (tick == '0)); // R2

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!stretch) |-> (tick <= LAST_NORM)); // R7
endmodule

// File: rtl/cpuclk_cycle_index.sv
// Module cpuclk_cycle_index
// Counts processor cycles from 0 to CYCLES-1 and flags the last one as long.
// Assumes adv pulses for exactly one master tick at the end of each cycle.
module cpuclk_cycle_index #(
    parameter int unsigned CYCLES = 65,
    localparam int unsigned IW    = $clog2(CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          is_long
);
    localparam logic [IW-1:0] LAST_IDX = IW'(CYCLES - 1);

    // Mark the stretched cycle, which is always the final one of the round.
    always_comb begin
        is_long = (idx == LAST_IDX);
    end

    // Step the cycle index at each cycle end and wrap after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            idx <= is_long ? '0 : idx + 1'b1;
        end
    end

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && idx == LAST_IDX) |=> (idx == '0)); // R5

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1)); // R5

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv) |=> $stable(idx)); // R5
endmodule

// File: rtl/cpuclk_stretch.sv
// Module cpuclk_stretch (top)
// Produces two-phase processor enables from the master clock.
// Every cycle lasts NORM_TICKS, except the last of each CYCLES round, which gets
// EXTRA_TICKS more at the end of its second phase.
// Assumes PH1_TICKS < NORM_TICKS and synchronous active-low reset.
module cpuclk_stretch #(
    parameter int unsigned NORM_TICKS  = cpuclk_pkg::DEF_NORM_TICKS,
    parameter int unsigned EXTRA_TICKS = cpuclk_pkg::DEF_EXTRA_TICKS,
    parameter int unsigned PH1_TICKS   = cpuclk_pkg::DEF_PH1_TICKS,
    parameter int unsigned CYCLES      = cpuclk_pkg::DEF_CYCLES,
    localparam int unsigned TW         = $clog2(NORM_TICKS + EXTRA_TICKS),
    localparam int unsigned IW         = $clog2(CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          phi1_en,
    output logic          phi2_en,
    output logic          cyc_start,
    output logic          long_cyc,
    output logic [IW-1:0] cyc_idx
);
    logic [TW-1:0] tick;
    logic          last_tick;
    logic          stretch;

    cpuclk_phase_timer #(
        .NORM  (NORM_TICKS),
        .EXTRA (EXTRA_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .stretch   (stretch),
        .tick      (tick),
        .last_tick (last_tick)
    );

    cpuclk_cycle_index #(
        .CYCLES (CYCLES)
    ) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (last_tick),
        .idx     (cyc_idx),
        .is_long (stretch)
    );

    // Decode the phase enables and the start strobe from the tick position.
    always_comb begin
        phi1_en   = (tick < TW'(PH1_TICKS));
        phi2_en   = !phi1_en;
        cyc_start = (tick == '0);
        long_cyc  = stretch;
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({phi1_en, phi2_en}) == 1)); // R3

    AST_START_IN_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> phi1_en); // R4

    AST_PH2_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phi2_en) |-> cyc_start); // R4

    AST_LONG_ENDS_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(long_cyc) |-> (cyc_start && cyc_idx == '0)); // R6
endmodule

// File: tb/sim_cpuclk_stretch.sv
module sim_cpuclk_stretch;
    localparam int NORM = 14, EXTRA = 2, PH1 = 7, NCYC = 65;
    localparam int ROUND = (NCYC - 1) * NORM + NORM + EXTRA; // 912

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phi1_en, phi2_en, cyc_start, long_cyc;
    logic [6:0] cyc_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cpuclk_stretch u0 (
        .clk(clk), .rst_n(rst_n), .phi1_en(phi1_en), .phi2_en(phi2_en),
        .cyc_start(cyc_start), .long_cyc(long_cyc), .cyc_idx(cyc_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: tick and cycle position after each rising edge.
    int m_tick = 0, m_cyc = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick = 0; m_cyc = 0;
        end else if (m_tick == ((m_cyc == NCYC - 1) ? NORM + EXTRA : NORM) - 1) begin
            m_tick = 0; m_cyc = (m_cyc + 1) % NCYC;
        end else begin
            m_tick++;
        end
    end

    // Measurement state kept from observed outputs.
    int len_cnt = 0, ph2_cnt = 0, prev_idx = 0, round_cnt = 0;
    bit seen_start = 0, seen_round = 0;

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            seen_start = 0; seen_round = 0;
        end else begin
            chk(phi1_en == (m_tick < PH1), "R2 phi1", phi1_en, m_tick < PH1);
            chk(($countones({phi1_en, phi2_en}) == 1), "R3 one phase", {phi1_en, phi2_en}, 1);
            chk(cyc_start == (m_tick == 0), "R4 start", cyc_start, m_tick == 0);
            chk(int'(cyc_idx) == m_cyc, "R5 index", cyc_idx, m_cyc);
            chk(long_cyc == (m_cyc == NCYC - 1), "R6 long flag", long_cyc, m_cyc == NCYC - 1);
            if (cyc_start) begin
                if (seen_start) begin
                    chk(len_cnt == ((prev_idx == NCYC - 1) ? NORM + EXTRA : NORM),
                        "R2/R7 cycle length", len_cnt,
                        (prev_idx == NCYC - 1) ? NORM + EXTRA : NORM);
                    chk(ph2_cnt == ((prev_idx == NCYC - 1) ? NORM + EXTRA - PH1 : NORM - PH1),
                        "R7 phase2 length", ph2_cnt,
                        (prev_idx == NCYC - 1) ? NORM + EXTRA - PH1 : NORM - PH1);
                end
                if (cyc_idx == 0) begin
                    if (seen_round) chk(round_cnt == ROUND, "R8 round ticks", round_cnt, ROUND);
                    seen_round = 1; round_cnt = 0;
                end
                seen_start = 1; len_cnt = 0; ph2_cnt = 0; prev_idx = int'(cyc_idx);
            end
            len_cnt++; round_cnt++;
            if (phi2_en) ph2_cnt++;
        end
    end

    task automatic reset_check();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(phi1_en && !phi2_en && cyc_start && !long_cyc && cyc_idx == 0,
            "R1 reset state", {phi1_en, phi2_en, cyc_start, long_cyc, cyc_idx}, 11'b10100000000);
        rst_n = 1'b1;
    endtask

    initial begin
        reset_check();
        repeat (3 * ROUND + 20) @(posedge clk);
        reset_check();                          // R1 reset taken mid-cycle
        repeat (3 * ROUND - 5) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule